// File: doc/BRIEF.md
# Predicated Absolute Max/Min Vector Unit

This block processes one 128-bit vector operation per accepted transfer. The source vector is split into signed lanes of 8, 16 or 32 bits, and each lane is replaced by its magnitude. That magnitude is compared, as an unsigned number, with the matching lane of an unsigned accumulator vector. Depending on the operation select, the unit keeps either the larger or the smaller of the two values. A 16-bit byte predicate then chooses, byte by byte, whether the new value or the old accumulator byte appears in the result.

Operands arrive on a valid/ready input channel, and the result leaves on a valid/ready output channel after a single register stage. The input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its valid flag are held unchanged and no new input is taken.

Top module: `absmm_unit`

## Requirements
- R1: `in_size` selects the lane width: 2'b00 gives 16 lanes of 8 bits, 2'b01 gives 8 lanes of 16 bits and 2'b10 gives 4 lanes of 32 bits. Lane k occupies bits k*W+W-1 down to k*W.
- R2: Each source lane is read as two's complement and replaced by its magnitude before the comparison. The most negative value is not saturated, so 0x80 at 8 bits becomes 128.
- R3: With `in_op`=0, each lane's new value is the unsigned maximum of the accumulator lane and the source magnitude.
- R4: With `in_op`=1, each lane's new value is the unsigned minimum of the accumulator lane and the source magnitude.
- R5: Output byte i, at bits 8i+7:8i, takes the new value when `in_mask[i]` is 1. When the bit is 0, the byte keeps the accumulator byte. Because of this, an element can be only partly written.
- R6: Size code 2'b11 is reserved, and for it the output equals `in_dst` whatever the mask and operation are.
- R7: A transfer accepted at one rising edge appears on `out_data` with `out_valid` high right after the next rising edge. Without a new transfer, `out_valid` drops once the result has been taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold steady and `in_ready` is low.
- R9: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take an input transfer |
| in_dst | input | 128 | Unsigned accumulator vector |
| in_src | input | 128 | Signed source vector |
| in_mask | input | 16 | Byte write predicate, bit i covers byte i |
| in_size | input | 2 | Lane width code |
| in_op | input | 1 | 0 selects maximum, 1 selects minimum |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Merged result vector |

## Verification
The most negative lane value is driven at every width. This tells an unsaturated magnitude apart from a clamped one, and an unsigned comparison apart from a signed one. All-ones sources and accumulators, together with zero lanes, show whether maximum and minimum are swapped and whether lane boundaries are placed correctly for each size code. Sparse and alternating byte masks on wide lanes show that write-back works per byte rather than per element. Random vectors, with random masks, sizes and operations, cover the remaining combinations, and a stalled consumer exposes any hold or acceptance error.

// File: rtl/absmm_pkg.sv
package absmm_pkg;
  localparam int unsigned DEF_VEC_W  = 128;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned NUM_SIZES  = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_code_e;

  typedef enum logic {
    OP_MAX = 1'b0,
    OP_MIN = 1'b1
  } sel_op_e;
endpackage

// File: rtl/absmm_elem.sv
module absmm_elem #(
  parameter int unsigned EW = 8
) (
  input  logic [EW-1:0] acc_i,
  input  logic [EW-1:0] src_i,
  input  logic          pick_min_i,
  output logic [EW-1:0] res_o
);
  logic [EW-1:0] mag;
  logic          acc_above;

  always_comb begin
    // two's complement magnitude, wraps for the most negative value
    mag       = src_i[EW-1] ? (~src_i + EW'(1)) : src_i;
    acc_above = acc_i > mag;
    res_o     = (acc_above ^ pick_min_i) ? acc_i : mag;
  end
endmodule

// File: rtl/absmm_bank.sv
module absmm_bank #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 8
) (
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic             pick_min_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned LANES = VEC_W / EW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    absmm_elem #(.EW(EW)) u_elem (
      .acc_i      (acc_i[l*EW +: EW]),
      .src_i      (src_i[l*EW +: EW]),
      .pick_min_i (pick_min_i),
      .res_o      (res_o[l*EW +: EW])
    );
  end
endmodule

// File: rtl/absmm_merge.sv
module absmm_merge #(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_SIZES = 3
) (
  input  logic [N_SIZES-1:0][VEC_W-1:0] cand_i,
  input  logic [VEC_W-1:0]              acc_i,
  input  logic [VEC_W/BYTE_W-1:0]       mask_i,
  input  logic [1:0]                    size_i,
  output logic [VEC_W-1:0]              res_o
);
  localparam int unsigned NB = VEC_W / BYTE_W;

  logic [VEC_W-1:0] chosen;

  always_comb begin
    chosen = acc_i;
    for (int s = 0; s < int'(N_SIZES); s++) begin
      if (int'(size_i) == s) chosen = cand_i[s];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign res_o[b*BYTE_W +: BYTE_W] = mask_i[b] ? chosen[b*BYTE_W +: BYTE_W]
                                                 : acc_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/absmm_unit.sv
module absmm_unit #(
  parameter int unsigned VEC_W  = absmm_pkg::DEF_VEC_W,
  parameter int unsigned BYTE_W = absmm_pkg::DEF_BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [VEC_W-1:0]        in_dst,
  input  logic [VEC_W-1:0]        in_src,
  input  logic [VEC_W/BYTE_W-1:0] in_mask,
  input  logic [1:0]              in_size,
  input  logic                    in_op,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [VEC_W-1:0]        out_data
);
  import absmm_pkg::*;

  localparam int unsigned N_SIZES = NUM_SIZES;

  logic [N_SIZES-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0]              merged;
  logic                          vld_q;
  logic [VEC_W-1:0]              data_q;
  logic                          accept;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    absmm_bank #(.VEC_W(VEC_W), .EW(BYTE_W << g)) u_bank (
      .acc_i      (in_dst),
      .src_i      (in_src),
      .pick_min_i (in_op == OP_MIN),
      .res_o      (cand[g])
    );
  end

  absmm_merge #(.VEC_W(VEC_W), .BYTE_W(BYTE_W), .N_SIZES(N_SIZES)) u_merge (
    .cand_i (cand),
    .acc_i  (in_dst),
    .mask_i (in_mask),
    .size_i (in_size),
    .res_o  (merged)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (accept) data_q <= merged;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/absmm_checker.sv
module absmm_checker #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [VEC_W-1:0]        in_dst,
  input logic [VEC_W/BYTE_W-1:0] in_mask,
  input logic [1:0]              in_size,
  input logic                    in_op,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [VEC_W-1:0]        out_data
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

  p_reserved_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b11) |=> (out_data == $past(in_dst)));

  p_empty_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_mask == '0) |=> (out_data == $past(in_dst)));

  p_max_not_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_op && in_size == 2'b00 && in_mask[0])
      |=> (out_data[BYTE_W-1:0] >= $past(in_dst[BYTE_W-1:0])));

  p_min_not_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op && in_size == 2'b00 && in_mask[0])
      |=> (out_data[BYTE_W-1:0] <= $past(in_dst[BYTE_W-1:0])));
endmodule

bind absmm_unit absmm_checker #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_absmm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_dst    (in_dst),
  .in_mask   (in_mask),
  .in_size   (in_size),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/absmm_unit_bench.sv
module absmm_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_dst = '0;
  logic [127:0] in_src = '0;
  logic [15:0]  in_mask = '0;
  logic [1:0]   in_size = '0;
  logic         in_op = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absmm_unit u_absmm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .in_mask(in_mask), .in_size(in_size),
    .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic [15:0] m, input logic [1:0] sz,
                                         input logic op);
    logic [127:0] r;
    logic [63:0]  lim, dv, sv, av, rv;
    int nb, bits;
    r = d;
    if (sz == 2'b11) return d;
    nb = 1 << sz;
    bits = 8 * nb;
    lim = (64'd1 << bits) - 64'd1;
    for (int e = 0; e < 16 / nb; e++) begin
      dv = '0;
      sv = '0;
      for (int b = 0; b < bits; b++) begin
        dv[b] = d[e*bits + b];
        sv[b] = s[e*bits + b];
      end
      av = sv[bits-1] ? ((~sv + 64'd1) & lim) : sv;
      rv = op ? ((dv < av) ? dv : av) : ((dv > av) ? dv : av);
      for (int k = 0; k < nb; k++)
        if (m[e*nb + k])
          for (int b = 0; b < 8; b++) r[(e*nb + k)*8 + b] = rv[k*8 + b];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] d, input logic [127:0] s, input logic [15:0] m,
                      input logic [1:0] sz, input logic op, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_dst = d; in_src = s; in_mask = m; in_size = sz; in_op = op;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R7 valid"}, {127'd0, out_valid}, 128'd1);
    chk(req, out_data, model(d, s, m, sz, op));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a_exp;
    logic [127:0] b_d, b_s;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", {127'd0, out_valid}, 128'd0);
    chk("R9 in_ready in reset", {127'd0, in_ready}, 128'd1);
    @(negedge clk) rst_n = 1'b1;

    // most negative per width, max: unsaturated magnitude beats small acc
    send({16{8'h05}}, {16{8'h80}}, 16'hFFFF, 2'b00, 1'b0, "R2 R1 byte most negative max");
    send({8{16'h0005}}, {8{16'h8000}}, 16'hFFFF, 2'b01, 1'b0, "R2 R1 half most negative max");
    send({4{32'h0000_0005}}, {4{32'h8000_0000}}, 16'hFFFF, 2'b10, 1'b0, "R2 R1 word most negative max");
    // most negative, min: unsigned compare keeps 0x80 over 0xF0
    send({16{8'hF0}}, {16{8'h80}}, 16'hFFFF, 2'b00, 1'b1, "R4 R2 byte most negative min");
    // all-ones source is -1, magnitude 1
    send({16{8'hFF}}, {128{1'b1}}, 16'hFFFF, 2'b00, 1'b1, "R4 all ones min");
    send({128{1'b1}}, {128{1'b1}}, 16'hFFFF, 2'b10, 1'b0, "R3 all ones max");
    send('0, '0, 16'hFFFF, 2'b01, 1'b0, "R3 zero max");
    send({16{8'h33}}, '0, 16'hFFFF, 2'b00, 1'b1, "R4 zero source min");
    // lane boundary: 0x00FF as 16-bit is positive 255
    send({8{16'h0100}}, {8{16'h00FF}}, 16'hFFFF, 2'b01, 1'b0, "R1 half boundary max");
    // partial element write on 32-bit lanes
    send({4{32'h1111_1111}}, {4{32'hF000_0000}}, 16'h5555, 2'b10, 1'b0, "R5 alternating mask word");
    send({4{32'h1111_1111}}, {4{32'hF000_0000}}, 16'h8001, 2'b10, 1'b0, "R5 sparse mask word");
    send({16{8'hA5}}, {16{8'h7F}}, 16'h0000, 2'b00, 1'b0, "R5 empty mask");
    send({16{8'h12}}, {16{8'h80}}, 16'hFFFF, 2'b11, 1'b0, "R6 reserved size max");
    send({16{8'h12}}, {16{8'h80}}, 16'hFFFF, 2'b11, 1'b1, "R6 reserved size min");

    // R7: idle after result taken
    @(negedge clk);
    chk("R7 valid drops when idle", {127'd0, out_valid}, 128'd0);

    // R8: back-pressure
    out_ready = 1'b0;
    send({16{8'h01}}, {16{8'hC0}}, 16'hFFFF, 2'b00, 1'b0, "R8 first item");
    a_exp = model({16{8'h01}}, {16{8'hC0}}, 16'hFFFF, 2'b00, 1'b0);
    b_d = {4{32'h2222_0000}};
    b_s = {4{32'h0000_1234}};
    in_valid = 1'b1; in_dst = b_d; in_src = b_s; in_mask = 16'hFFFF; in_size = 2'b10; in_op = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R8 in_ready low while stalled", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
      chk("R8 data held", out_data, a_exp);
      chk("R8 valid held", {127'd0, out_valid}, 128'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second item after release", out_data, model(b_d, b_s, 16'hFFFF, 2'b10, 1'b1));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [127:0] d, s;
      logic [15:0]  m;
      logic [1:0]   sz;
      logic         op;
      for (int w = 0; w < 4; w++) begin
        d[w*32 +: 32] = $urandom;
        s[w*32 +: 32] = $urandom;
      end
      m  = ($urandom % 2 == 0) ? 16'hFFFF : 16'($urandom);
      sz = 2'($urandom % 4);
      op = 1'($urandom);
      if (sz == 2'b11) send(d, s, m, sz, op, "R6 random reserved");
      else if (op) send(d, s, m, sz, op, "R4 R5 random min");
      else send(d, s, m, sz, op, "R3 R5 random max");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule